// File: doc/BRIEF.md
# Serial Audio Port Control and Clock-Domain Synchroniser

This block holds the control and status word of a serial audio port. Software reads and writes the word on the system clock, while the port's shifters run on a separate, slower bit clock that may stop. The block carries four levels into the bit-clock domain: the global enable, the receive run bit, the transmit run bit and the standby release. After the standby release it raises a ready level once a fixed number of bit-clock cycles has passed. Each FIFO clear request written by software becomes a self-clearing strobe. The strobe crosses as a toggle and comes out as a one-cycle pulse in the bit-clock domain.

A sync bit gives software a liveness handshake. The value written to it passes through a two-flop synchroniser into the bit-clock domain and then through a second two-flop synchroniser back. Only after that round trip does the readable copy take the new value. When the read-back matches what was written, every earlier command has reached the bit-clock side. The word also shows four FIFO level flags from the FIFO logic and two sticky error flags. Writing 1 to an error flag clears it.

Top module: `aport_ctrl`

## Requirements
- R1: While reset is asserted and right after it, `rd_data` reads all zero and every bit-clock-domain output is 0.
- R2: A write stores bit 0 (enable), bit 1 (receive run), bit 2 (transmit run) and bit 25 (standby release). These read back at the same positions and reach `b_enable`, `b_rx_run`, `b_tx_run` and `b_powered` within a few bit-clock cycles.
- R3: Bits 3 and 4 are write-only strobes and always read 0. All bit positions that this word does not define also read 0.
- R4: A write with bit 3 set gives exactly one `b_tx_clear` pulse, one bit-clock cycle wide. A write with bit 4 set gives exactly one `b_rx_clear` pulse. A write with either bit clear gives no pulse on the matching output.
- R5: After bit 24 (sync) is written, its read-back keeps the old value for at least two system cycles. It shows the written value only after two bit-clock edges and two system edges have passed.
- R6: While the bit clock is stopped, the sync read-back keeps its old value for as long as the stop lasts. When the bit clock restarts, the handshake completes.
- R7: Bit 21 shows `tx_fifo_empty`, bit 20 shows `rx_fifo_has_data`, bit 17 shows `tx_fifo_low` and bit 18 shows `rx_fifo_high`, each in the same cycle as its input.
- R8: The transmit error flag (bit 15) is set by `tx_underrun` and the receive error flag (bit 16) by `rx_overrun`. Each flag stays set until a write has 1 at its position, and a written 0 leaves it unchanged. When the event and the clearing write arrive in the same cycle, the flag stays set.
- R9: `b_ready` rises exactly STBY_CYCLES bit-clock edges after `b_powered` rises. It falls when the standby release is withdrawn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| bclk | input | 1 | Bit clock; may stop |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | WORD | Value written to the control word |
| rd_data | output | WORD | Readable control and status word |
| tx_fifo_empty | input | 1 | Transmit FIFO empty |
| rx_fifo_has_data | input | 1 | Receive FIFO holds data |
| tx_fifo_low | input | 1 | Transmit FIFO needs writes |
| rx_fifo_high | input | 1 | Receive FIFO needs reads |
| tx_underrun | input | 1 | Transmit error event, one system cycle |
| rx_overrun | input | 1 | Receive error event, one system cycle |
| b_enable | output | 1 | Global enable in the bit-clock domain |
| b_rx_run | output | 1 | Receive run in the bit-clock domain |
| b_tx_run | output | 1 | Transmit run in the bit-clock domain |
| b_powered | output | 1 | Standby released, bit-clock domain |
| b_ready | output | 1 | Port usable after the standby delay |
| b_tx_clear | output | 1 | One-cycle transmit FIFO clear pulse |
| b_rx_clear | output | 1 | One-cycle receive FIFO clear pulse |

## Verification
The one-cycle-pulse properties assume that two clear writes to the same direction are spaced by several bit-clock periods. Otherwise two toggles could merge inside the synchroniser. The echo property assumes that software does not write a new sync value until the previous one has come back. The stimulus keeps to both: after every clear write it waits ten bit-clock periods, and it polls the sync read-back before each new sync value. Error events are driven for a single system cycle, and the FIFO flag inputs change only away from clock edges.

// File: rtl/aport_pkg.sv
package aport_pkg;
  localparam int BIT_EN      = 0;
  localparam int BIT_RXON    = 1;
  localparam int BIT_TXON    = 2;
  localparam int BIT_TXCLR   = 3;
  localparam int BIT_RXCLR   = 4;
  localparam int BIT_TXERR   = 15;
  localparam int BIT_RXERR   = 16;
  localparam int BIT_TXLOW   = 17;
  localparam int BIT_RXHIGH  = 18;
  localparam int BIT_RXHAS   = 20;
  localparam int BIT_TXEMPTY = 21;
  localparam int BIT_SYNC    = 24;
  localparam int BIT_STBY    = 25;

  typedef struct packed {
    logic stby;
    logic tx_on;
    logic rx_on;
    logic en;
  } ctl_t;
endpackage

// File: rtl/aport_bitsync.sv
module aport_bitsync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg <= '0;
    else        stg <= {stg[STAGES-2:0], d};
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/aport_pulse_xfer.sv
module aport_pulse_xfer #(
  parameter int STAGES = 2
) (
  input  logic s_clk,
  input  logic d_clk,
  input  logic rst_n,
  input  logic s_strobe,
  output logic d_pulse
);
  logic s_tog, d_tog, d_last;

  always_ff @(posedge s_clk or negedge rst_n) begin
    if (!rst_n)        s_tog <= 1'b0;
    else if (s_strobe) s_tog <= ~s_tog;
  end

  aport_bitsync #(.W(1), .STAGES(STAGES)) u_sync (
    .clk(d_clk), .rst_n(rst_n), .d(s_tog), .q(d_tog)
  );

  always_ff @(posedge d_clk or negedge rst_n) begin
    if (!rst_n) d_last <= 1'b0;
    else        d_last <= d_tog;
  end

  assign d_pulse = d_tog ^ d_last;
endmodule

// File: rtl/aport_sync_echo.sv
module aport_sync_echo #(
  parameter int STAGES = 2
) (
  input  logic s_clk,
  input  logic d_clk,
  input  logic rst_n,
  input  logic s_req,
  output logic s_echo
);
  logic d_seen;

  aport_bitsync #(.W(1), .STAGES(STAGES)) u_fwd (
    .clk(d_clk), .rst_n(rst_n), .d(s_req), .q(d_seen)
  );

  aport_bitsync #(.W(1), .STAGES(STAGES)) u_back (
    .clk(s_clk), .rst_n(rst_n), .d(d_seen), .q(s_echo)
  );
endmodule

// File: rtl/aport_ctrl.sv
module aport_ctrl
  import aport_pkg::*;
#(
  parameter int WORD        = 32,
  parameter int STAGES      = 2,
  parameter int STBY_CYCLES = 4
) (
  input  logic            clk,
  input  logic            bclk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [WORD-1:0] wr_data,
  output logic [WORD-1:0] rd_data,
  input  logic            tx_fifo_empty,
  input  logic            rx_fifo_has_data,
  input  logic            tx_fifo_low,
  input  logic            rx_fifo_high,
  input  logic            tx_underrun,
  input  logic            rx_overrun,
  output logic            b_enable,
  output logic            b_rx_run,
  output logic            b_tx_run,
  output logic            b_powered,
  output logic            b_ready,
  output logic            b_tx_clear,
  output logic            b_rx_clear
);
  localparam int CW = $clog2(STBY_CYCLES + 1);
  localparam int NCLR = 2;

  ctl_t           ctl_q, b_ctl;
  logic           sync_req, sync_echo;
  logic           tx_err_q, rx_err_q;
  logic [CW-1:0]  stby_cnt;
  logic [NCLR-1:0] clr_strobe, clr_pulse;

  // System-side control word
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q    <= '0;
      sync_req <= 1'b0;
    end else if (wr_en) begin
      ctl_q.en    <= wr_data[BIT_EN];
      ctl_q.rx_on <= wr_data[BIT_RXON];
      ctl_q.tx_on <= wr_data[BIT_TXON];
      ctl_q.stby  <= wr_data[BIT_STBY];
      sync_req    <= wr_data[BIT_SYNC];
    end
  end

  // Sticky error flags: an event outranks a clearing write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_err_q <= 1'b0;
      rx_err_q <= 1'b0;
    end else begin
      tx_err_q <= tx_underrun | (tx_err_q & ~(wr_en & wr_data[BIT_TXERR]));
      rx_err_q <= rx_overrun  | (rx_err_q & ~(wr_en & wr_data[BIT_RXERR]));
    end
  end

  // Level controls into the bit-clock domain
  aport_bitsync #(.W($bits(ctl_t)), .STAGES(STAGES)) u_ctl_sync (
    .clk(bclk), .rst_n(rst_n), .d(ctl_q), .q(b_ctl)
  );

  assign b_enable  = b_ctl.en;
  assign b_rx_run  = b_ctl.rx_on;
  assign b_tx_run  = b_ctl.tx_on;
  assign b_powered = b_ctl.stby;

  // Standby settling counter in the bit-clock domain
  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n)                          stby_cnt <= '0;
    else if (!b_powered)                 stby_cnt <= '0;
    else if (stby_cnt != CW'(STBY_CYCLES)) stby_cnt <= stby_cnt + 1'b1;
  end

  assign b_ready = b_powered && (stby_cnt == CW'(STBY_CYCLES));

  // FIFO clear strobes: index 0 transmit, index 1 receive
  assign clr_strobe = {wr_en & wr_data[BIT_RXCLR], wr_en & wr_data[BIT_TXCLR]};

  for (genvar gi = 0; gi < NCLR; gi++) begin : g_clr
    aport_pulse_xfer #(.STAGES(STAGES)) u_xfer (
      .s_clk(clk), .d_clk(bclk), .rst_n(rst_n),
      .s_strobe(clr_strobe[gi]), .d_pulse(clr_pulse[gi])
    );
  end

  assign b_tx_clear = clr_pulse[0];
  assign b_rx_clear = clr_pulse[1];

  // Round-trip sync handshake
  aport_sync_echo #(.STAGES(STAGES)) u_echo (
    .s_clk(clk), .d_clk(bclk), .rst_n(rst_n),
    .s_req(sync_req), .s_echo(sync_echo)
  );

  // Read-back word
  always_comb begin
    rd_data              = '0;
    rd_data[BIT_EN]      = ctl_q.en;
    rd_data[BIT_RXON]    = ctl_q.rx_on;
    rd_data[BIT_TXON]    = ctl_q.tx_on;
    rd_data[BIT_STBY]    = ctl_q.stby;
    rd_data[BIT_SYNC]    = sync_echo;
    rd_data[BIT_TXERR]   = tx_err_q;
    rd_data[BIT_RXERR]   = rx_err_q;
    rd_data[BIT_TXLOW]   = tx_fifo_low;
    rd_data[BIT_RXHIGH]  = rx_fifo_high;
    rd_data[BIT_RXHAS]   = rx_fifo_has_data;
    rd_data[BIT_TXEMPTY] = tx_fifo_empty;
  end
endmodule

// File: rtl/aport_ctrl_chk.sv
module aport_ctrl_chk #(
  parameter int WORD = 32
) (
  input logic            clk,
  input logic            bclk,
  input logic            rst_n,
  input logic            wr_en,
  input logic [WORD-1:0] wr_data,
  input logic [WORD-1:0] rd_data,
  input logic            tx_underrun,
  input logic            rx_overrun,
  input logic            b_tx_clear,
  input logic            b_rx_clear,
  input logic            b_powered,
  input logic            b_ready,
  input logic            sync_req
);
  AST_STROBES_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[3] == 1'b0) && (rd_data[4] == 1'b0)); // R3

  AST_TXCLR_ONE_CYCLE: assert property (@(posedge bclk) disable iff (!rst_n)
    b_tx_clear |=> !b_tx_clear); // R4

  AST_RXCLR_ONE_CYCLE: assert property (@(posedge bclk) disable iff (!rst_n)
    b_rx_clear |=> !b_rx_clear); // R4

  AST_ECHO_MOVES_TO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_data[24]) |-> (rd_data[24] == sync_req)); // R5

  AST_TXERR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    tx_underrun |=> rd_data[15]); // R8

  AST_RXERR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overrun |=> rd_data[16]); // R8

  AST_TXERR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[15] && !(wr_en && wr_data[15])) |=> rd_data[15]); // R8

  AST_TXERR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[15] && !tx_underrun) |=> !rd_data[15]); // R8

  AST_READY_AFTER_POWER: assert property (@(posedge bclk) disable iff (!rst_n)
    $rose(b_ready) |-> $past(b_powered)); // R9
endmodule

bind aport_ctrl aport_ctrl_chk #(.WORD(WORD)) u_chk (.*);

// File: tb/aport_ctrl_test.sv
module aport_ctrl_test;
  localparam int WORD = 32;
  localparam int STBY = 4;

  logic clk = 1'b0, bclk = 1'b0, rst_n = 1'b0, bclk_run = 1'b1;
  logic wr_en = 1'b0;
  logic [WORD-1:0] wr_data = '0;
  logic [WORD-1:0] rd_data;
  logic tx_fifo_empty = 0, rx_fifo_has_data = 0, tx_fifo_low = 0, rx_fifo_high = 0;
  logic tx_underrun = 0, rx_overrun = 0;
  logic b_enable, b_rx_run, b_tx_run, b_powered, b_ready, b_tx_clear, b_rx_clear;

  int n_vec = 0, n_bad = 0;
  int tx_pulses = 0, rx_pulses = 0;
  bit done = 0;

  aport_ctrl #(.WORD(WORD), .STBY_CYCLES(STBY)) uut (.*);

  always #5 clk = ~clk;
  always begin
    #20;
    if (bclk_run) bclk = ~bclk;
  end

  always @(negedge bclk) begin
    if (b_tx_clear) tx_pulses++;
    if (b_rx_clear) rx_pulses++;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [WORD-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [WORD-1:0] exp;
    int n, tx0, rx0;

    // R1: reset state
    idle(3);
    check(rd_data == '0, "R1 rd during reset", rd_data, 0);
    rst_n = 1'b1;
    idle(2);
    check(rd_data == '0, "R1 rd after reset", rd_data, 0);
    check({b_enable, b_rx_run, b_tx_run, b_powered, b_ready, b_tx_clear, b_rx_clear} == 7'd0,
          "R1 bclk outputs", {b_enable, b_rx_run, b_tx_run, b_powered, b_ready}, 0);

    // R7: every status flag pattern
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      {tx_fifo_empty, rx_fifo_has_data, tx_fifo_low, rx_fifo_high} = 4'(i);
      #2;
      exp = '0;
      exp[21] = i[3]; exp[20] = i[2]; exp[17] = i[1]; exp[18] = i[0];
      check(rd_data == exp, "R7 status flags", rd_data, exp);
    end
    {tx_fifo_empty, rx_fifo_has_data, tx_fifo_low, rx_fifo_high} = 4'd0;

    // R2/R3: every control level combination, undefined bits written as ones
    for (int c = 0; c < 16; c++) begin
      logic [WORD-1:0] d;
      d = 32'hFCEE_7FE0;
      d[0] = c[0]; d[1] = c[1]; d[2] = c[2]; d[25] = c[3];
      wr(d);
      exp = '0;
      exp[0] = c[0]; exp[1] = c[1]; exp[2] = c[2]; exp[25] = c[3];
      check(rd_data == exp, "R2/R3 readback", rd_data, exp);
      idle(30);
      check({b_powered, b_tx_run, b_rx_run, b_enable} == 4'(c), "R2 bclk levels",
            {b_powered, b_tx_run, b_rx_run, b_enable}, c);
    end

    // R9: standby settle time
    wr('0);
    idle(30);
    check(b_ready == 1'b0, "R9 ready low when in standby", b_ready, 0);
    wr(32'h0200_0000);
    wait (b_powered);
    n = 0;
    while (!b_ready && n < 50) begin
      @(posedge bclk); #1; n++;
    end
    check(n == STBY, "R9 bclk edges to ready", n, STBY);
    wr('0);
    idle(30);
    check(b_ready == 1'b0, "R9 ready drops", b_ready, 0);

    // R4/R3: clear strobes in every combination
    for (int p = 0; p < 4; p++) begin
      tx0 = tx_pulses; rx0 = rx_pulses;
      wr({27'd0, p[1], p[0], 3'b001});
      check(rd_data[4:3] == 2'b00, "R3 clear bits read zero", rd_data[4:3], 0);
      idle(40);
      check(tx_pulses - tx0 == int'(p[0]), "R4 tx clear pulses", tx_pulses - tx0, p[0]);
      check(rx_pulses - rx0 == int'(p[1]), "R4 rx clear pulses", rx_pulses - rx0, p[1]);
    end

    // R8: sticky error flags
    @(negedge clk); tx_underrun = 1'b1; @(negedge clk); tx_underrun = 1'b0;
    check(rd_data[15] == 1'b1, "R8 tx error set", rd_data[15], 1);
    idle(5);
    check(rd_data[15] == 1'b1, "R8 tx error sticky", rd_data[15], 1);
    wr(32'h0001_0000);
    check(rd_data[15] == 1'b1, "R8 tx error kept by written 0", rd_data[15], 1);
    wr(32'h0000_8000);
    check(rd_data[15] == 1'b0, "R8 tx error cleared by 1", rd_data[15], 0);
    @(negedge clk); rx_overrun = 1'b1; @(negedge clk); rx_overrun = 1'b0;
    check(rd_data[16] == 1'b1, "R8 rx error set", rd_data[16], 1);
    @(negedge clk); rx_overrun = 1'b1; wr_en = 1'b1; wr_data = 32'h0001_0000;
    @(negedge clk); rx_overrun = 1'b0; wr_en = 1'b0; wr_data = '0;
    check(rd_data[16] == 1'b1, "R8 event outranks clear", rd_data[16], 1);
    wr(32'h0001_0000);
    check(rd_data[16] == 1'b0, "R8 rx error cleared", rd_data[16], 0);

    // R5: sync round trip in both directions
    for (int v = 1; v >= 0; v--) begin
      wr({7'd0, 1'(v), 24'd0});
      check(rd_data[24] == 1'(1 - v), "R5 echo not immediate", rd_data[24], 1 - v);
      n = 1;
      while (rd_data[24] != 1'(v) && n < 60) begin
        @(negedge clk); n++;
      end
      check(n >= 2 && n <= 20, "R5 echo latency", n, 20);
    end

    // R6: stopped bit clock holds the echo
    bclk_run = 1'b0;
    idle(20);
    wr(32'h0100_0000);
    idle(300);
    check(rd_data[24] == 1'b0, "R6 echo held while bclk stopped", rd_data[24], 0);
    bclk_run = 1'b1;
    idle(40);
    check(rd_data[24] == 1'b1, "R6 echo completes after restart", rd_data[24], 1);

    done = 1;
    finish_run();
  end
endmodule